// File: doc/BRIEF.md
# Gated Two-Pair Sum Maximum Pipeline

This block takes four unsigned operands of equal width, forms the two sums C+D and X+Y, and returns whichever sum is larger. The result is one bit wider than the operands, so it never wraps. The first stage registers the operands and feeds two adders. The second stage compares the two sums, selects the larger one and registers it. A result appears two clock edges after its operands were accepted.

To cut switching in whichever adder cannot win, a predictor looks at the most significant bit of each incoming operand. Suppose both C and D have their top bit set and both X and Y have it clear. Then C+D is certain to exceed X+Y, so the low bits of X and Y are not captured for that operand set. In the mirrored case the low bits of C and D are held instead. The predictor decision is registered beside the operands. In the next cycle it forces the output select toward the sum that is known to win, so the stale sum of the frozen pair is never used. The comparator decides only when neither prediction applies.

Top module: `pmax_top`

## Requirements
- R1: For every accepted operand set, `maxSum` equals the larger of C+D and X+Y as an unsigned (W+1)-bit value, with no wraparound.
- R2: An operand set accepted with `inValid` high at a rising edge produces its result on `maxSum`, with `outValid` high, after the second rising edge. `outValid` is `inValid` delayed by two edges.
- R3: When the two sums are equal, `maxSum` carries that common value.
- R4: When C and D both have bit W-1 set and X and Y both have it clear, the low W-1 bits of X and Y are not captured for that set, and the result is C+D.
- R5: When X and Y both have bit W-1 set and C and D both have it clear, the low W-1 bits of C and D are not captured for that set, and the result is X+Y.
- R6: The two predictor flags are never set together. When neither is set, the comparison of the two registered sums picks the result.
- R7: While `inValid` is low, no operand register loads. Two edges later `outValid` is low and `maxSum` keeps its previous value.
- R8: A synchronous reset clears the operand registers, the predictor flags and `maxSum`, and drives `outValid` low. No operand set accepted before the reset appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand set on the inputs is valid this cycle |
| opC | input | W | First operand of pair one |
| opD | input | W | Second operand of pair one |
| opX | input | W | First operand of pair two |
| opY | input | W | Second operand of pair two |
| maxSum | output | W+1 | Larger of the two pair sums |
| outValid | output | 1 | `maxSum` carries a fresh result |

## Verification
The bound checker keeps its own two-stage model of the maximum. On every cycle it checks the value and the timing of `outValid` and `maxSum`, that the two predictor flags are mutually exclusive, that each qualifying top-bit pattern raises the matching flag one edge later, and that the output holds across bubbles. Some effects show only in the bench's scenarios. One is a predicted set that follows a set with different low bits, where a wrong gate would leave a stale operand in the winning adder. Others are back-to-back opposite predictions, ties, the largest sums, and a reset that arrives with data in flight.

// File: rtl/pmax_pkg.sv
package pmax_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic ldTop;    // capture the top bit of all four operands
    logic ldLoCD;   // capture low bits of the C/D pair
    logic ldLoXY;   // capture low bits of the X/Y pair
    logic ldOut;    // capture the selected maximum
    logic forceCD;  // registered prediction: C+D wins
    logic forceXY;  // registered prediction: X+Y wins
  } pmaxCtl_t;

endpackage

// File: rtl/pmax_pair.sv
// Holds one operand pair with separate enables for the top bit and the
// low bits, and forms the widened sum of the pair.
module pmax_pair #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         topEn,
  input  logic         loEn,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W:0]   pairSum
);

  localparam int LoW = W - 1;

  logic           aTop, bTop;
  logic [LoW-1:0] aLo, bLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      aTop <= 1'b0;
      bTop <= 1'b0;
    end else if (topEn) begin
      aTop <= opA[W-1];
      bTop <= opB[W-1];
    end
  end

  // Low bits load only when this pair is not predicted to lose.
  always_ff @(posedge clk) begin
    if (rst) begin
      aLo <= '0;
      bLo <= '0;
    end else if (loEn) begin
      aLo <= opA[LoW-1:0];
      bLo <= opB[LoW-1:0];
    end
  end

  assign pairSum = {1'b0, aTop, aLo} + {1'b0, bTop, bLo};

endmodule

// File: rtl/pmax_ctrl.sv
// Top-bit predictor, flag registers and valid pipeline.
module pmax_ctrl
  import pmax_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     topC,
  input  logic     topD,
  input  logic     topX,
  input  logic     topY,
  output pmaxCtl_t ctl,
  output logic     outValid
);

  logic cdWinsNow, xyWinsNow;
  logic forceCDq, forceXYq;
  logic s1Valid, s2Valid;

  // Both top bits set on one side and clear on the other decides the max.
  assign cdWinsNow = topC & topD & ~topX & ~topY;
  assign xyWinsNow = topX & topY & ~topC & ~topD;

  always_ff @(posedge clk) begin
    if (rst) begin
      forceCDq <= 1'b0;
      forceXYq <= 1'b0;
    end else if (inValid) begin
      forceCDq <= cdWinsNow;
      forceXYq <= xyWinsNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
    end
  end

  always_comb begin
    ctl.ldTop   = inValid;
    ctl.ldLoCD  = inValid & ~xyWinsNow;
    ctl.ldLoXY  = inValid & ~cdWinsNow;
    ctl.ldOut   = s1Valid;
    ctl.forceCD = forceCDq;
    ctl.forceXY = forceXYq;
  end

  assign outValid = s2Valid;

endmodule

// File: rtl/pmax_dp.sv
// Operand pairs, adders, comparator, select and output register.
module pmax_dp
  import pmax_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  pmaxCtl_t     ctl,
  input  logic [W-1:0] opC,
  input  logic [W-1:0] opD,
  input  logic [W-1:0] opX,
  input  logic [W-1:0] opY,
  output logic [W:0]   maxSum
);

  localparam int NPair = 2;

  logic [W-1:0] opA [NPair];
  logic [W-1:0] opB [NPair];
  logic         loEn [NPair];
  logic [W:0]   sums [NPair];

  assign opA[0]  = opC;
  assign opB[0]  = opD;
  assign opA[1]  = opX;
  assign opB[1]  = opY;
  assign loEn[0] = ctl.ldLoCD;
  assign loEn[1] = ctl.ldLoXY;

  for (genvar p = 0; p < NPair; p++) begin : g_pair
    pmax_pair #(.W(W)) u_pair (
      .clk     (clk),
      .rst     (rst),
      .topEn   (ctl.ldTop),
      .loEn    (loEn[p]),
      .opA     (opA[p]),
      .opB     (opB[p]),
      .pairSum (sums[p])
    );
  end

  logic       pickCD;
  logic [W:0] nextMax;

  // A registered prediction overrides the comparator; the frozen pair's
  // sum is then never selected.
  always_comb begin
    if (ctl.forceCD)      pickCD = 1'b1;
    else if (ctl.forceXY) pickCD = 1'b0;
    else                  pickCD = (sums[0] >= sums[1]);
    nextMax = pickCD ? sums[0] : sums[1];
  end

  always_ff @(posedge clk) begin
    if (rst)            maxSum <= '0;
    else if (ctl.ldOut) maxSum <= nextMax;
  end

endmodule

// File: rtl/pmax_top.sv
module pmax_top
  import pmax_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [W-1:0] opC,
  input  logic [W-1:0] opD,
  input  logic [W-1:0] opX,
  input  logic [W-1:0] opY,
  output logic [W:0]   maxSum,
  output logic         outValid
);

  pmaxCtl_t ctl;

  pmax_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .topC     (opC[W-1]),
    .topD     (opD[W-1]),
    .topX     (opX[W-1]),
    .topY     (opY[W-1]),
    .ctl      (ctl),
    .outValid (outValid)
  );

  pmax_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .opC    (opC),
    .opD    (opD),
    .opX    (opX),
    .opY    (opY),
    .maxSum (maxSum)
  );

endmodule

// File: rtl/pmax_check.sv
module pmax_check #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [W-1:0] opC,
  input logic [W-1:0] opD,
  input logic [W-1:0] opX,
  input logic [W-1:0] opY,
  input logic [W:0]   maxSum,
  input logic         outValid,
  input logic         forceCD,
  input logic         forceXY
);

  logic [W:0] refCD, refXY, refMax;
  logic [W:0] exp1, exp2;
  logic       v1, v2;

  assign refCD  = {1'b0, opC} + {1'b0, opD};
  assign refXY  = {1'b0, opX} + {1'b0, opY};
  assign refMax = (refCD > refXY) ? refCD : refXY;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp1 <= '0;
      exp2 <= '0;
      v1   <= 1'b0;
      v2   <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      if (inValid) exp1 <= refMax;
      if (v1)      exp2 <= exp1;
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    outValid == v2);

  a_r1_max_value: assert property (@(posedge clk) disable iff (rst)
    outValid |-> maxSum == exp2);

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({forceCD, forceXY}));

  a_r4_predict_cd: assert property (@(posedge clk) disable iff (rst)
    (inValid && opC[W-1] && opD[W-1] && !opX[W-1] && !opY[W-1]) |=> forceCD);

  a_r5_predict_xy: assert property (@(posedge clk) disable iff (rst)
    (inValid && opX[W-1] && opY[W-1] && !opC[W-1] && !opD[W-1]) |=> forceXY);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> $stable(maxSum));

endmodule

bind pmax_top pmax_check #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .opC      (opC),
  .opD      (opD),
  .opX      (opX),
  .opY      (opY),
  .maxSum   (maxSum),
  .outValid (outValid),
  .forceCD  (ctl.forceCD),
  .forceXY  (ctl.forceXY)
);

// File: tb/sim_pmax_top.sv
`timescale 1ns/1ps
module sim_pmax_top;

  localparam int W = 8;
  localparam int NV = 14;

  // Each entry: {C, D, X, Y}
  localparam logic [4*W-1:0] VEC [NV] = '{
    32'h00000000, 32'h12345678, 32'h80801020, 32'h0102F0F1,
    32'hFFFF7F7F, 32'h7F7FFFFF, 32'h90105050, 32'h80808080,
    32'hC30000C4, 32'hFF018080, 32'h8583017E, 32'h007F403F,
    32'h7F7F8182, 32'hA0059F07
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [W-1:0] opC = '0, opD = '0, opX = '0, opY = '0;
  logic [W:0]   maxSum;
  logic         outValid;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pmax_top #(.W(W)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid),
    .opC(opC), .opD(opD), .opX(opX), .opY(opY),
    .maxSum(maxSum), .outValid(outValid)
  );

  function automatic logic [W:0] expMax(input logic [4*W-1:0] v);
    logic [W:0] a, b;
    a = {1'b0, v[4*W-1:3*W]} + {1'b0, v[3*W-1:2*W]};
    b = {1'b0, v[2*W-1:W]}   + {1'b0, v[W-1:0]};
    return (a > b) ? a : b;
  endfunction

  function automatic string tagOf(input logic [4*W-1:0] v);
    logic c, d, x, y;
    logic [W:0] a, b;
    c = v[4*W-1]; d = v[3*W-1]; x = v[2*W-1]; y = v[W-1];
    a = {1'b0, v[4*W-1:3*W]} + {1'b0, v[3*W-1:2*W]};
    b = {1'b0, v[2*W-1:W]}   + {1'b0, v[W-1:0]};
    if (c && d && !x && !y) return "R1,R4";
    if (x && y && !c && !d) return "R1,R5";
    if (a == b)             return "R1,R3";
    return "R1,R6";
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [4*W-1:0] ops);
    inValid = v;
    {opC, opD, opX, opY} = ops;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 outValid at reset", {{W{1'b0}}, outValid}, '0);
    check("R8 maxSum at reset", maxSum, '0);
    rst = 1'b0;

    // Stream the table back to back, then a two-cycle gap (R7).
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 2 && i - 2 < NV) begin
        check({tagOf(VEC[i-2]), " value"}, maxSum, expMax(VEC[i-2]));
        check("R2 outValid streaming", {{W{1'b0}}, outValid}, 1);
      end
      if (i >= NV + 2) begin
        check("R7 outValid in gap", {{W{1'b0}}, outValid}, 0);
        check("R7 maxSum held in gap", maxSum, expMax(VEC[NV-1]));
      end
      if (i < NV) drive(1'b1, VEC[i]);
      else        drive(1'b0, 32'hFEDCBA98);
    end

    // R2: isolated set, exact latency
    @(negedge clk);
    drive(1'b1, 32'h3C3C1111);
    @(negedge clk);
    drive(1'b0, 32'h0);
    check("R2 not yet valid", {{W{1'b0}}, outValid}, 0);
    @(negedge clk);
    check("R2 valid after two edges", {{W{1'b0}}, outValid}, 1);
    check("R2 value", maxSum, 9'h078);
    @(negedge clk);
    check("R2 single pulse", {{W{1'b0}}, outValid}, 0);

    // R4 then R1: predicted set, then an unpredicted set whose X/Y lows must reload
    drive(1'b1, 32'hC0C00305);
    @(negedge clk);
    drive(1'b1, 32'h01017F7E);
    @(negedge clk);
    drive(1'b0, 32'h0);
    check("R4 predicted C+D", maxSum, 9'h180);
    @(negedge clk);
    check("R1 X/Y lows reloaded", maxSum, 9'h0FD);

    // R8: reset with a set in flight
    @(negedge clk);
    drive(1'b1, 32'hFFFFFFFF);
    @(negedge clk);
    drive(1'b0, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    check("R8 maxSum cleared", maxSum, '0);
    check("R8 outValid cleared", {{W{1'b0}}, outValid}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 flushed set not emitted", {{W{1'b0}}, outValid}, 0);
    check("R8 maxSum stays clear", maxSum, '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule